// File: doc/BRIEF.md
# Store Buffer Drain Scheduler

This block decides when the line entries held in a store buffer are written out to the data cache. It holds the per-entry control state (valid, inflight, replay pending, same-block wait, forced drain) and the two counters each entry needs: an idle counter and a miss-replay counter. Line data, byte masks and load forwarding sit in neighbouring logic. The scheduler learns about allocations and merges through its inputs and drives only the cache write request channel.

An entry becomes a drain candidate for one of four reasons, checked in this order:
1. A tag mismatch was reported against it.
2. Its replay wait after a miss has finished.
3. It has sat untouched for the idle limit.
4. The buffer is in bulk drain, meaning a flush is requested or the valid count has reached the threshold.

Within the winning class the lowest index is chosen. The chosen entry is latched in a one-deep issue stage and offered on a valid/ready channel in the following cycle. A hit response frees the entry and releases any entries waiting on it. A miss response puts the entry into a timed replay wait.

Top module: `sbuf_drain_sched`

## Requirements
- R1: After reset no request is offered, no entry is valid or inflight, `freed_o` is zero and `flush_done_o` is low.
- R2: While the number of valid entries (inflight ones included) is at least `DRAIN_THRESH`, eligible entries are sent. Below it, with no other cause, nothing is sent.
- R3: While `flush_req_i` is high all eligible entries are sent, lowest index first. `flush_done_o` is high exactly when `flush_req_i` is high, no entry is valid and no request is offered.
- R4: A mismatch pulse naming a valid entry that is not inflight makes that entry drain even without flush or threshold. A mismatch naming an invalid entry has no effect.
- R5: An entry that becomes eligible in cycle t is offered from cycle t+1 on `req_valid_o`/`req_idx_o`. The offer holds with a stable index until `req_ready_i` is high; the transfer happens on that edge. The entry reads inflight from its selection until its response.
- R6: After a miss response the entry stays valid and inflight and is re-offered exactly 18 cycles after the edge on which the miss was taken. That is a replay counter running from 0 to `REPLAY_LIMIT` (16), plus selection and issue.
- R7: A valid entry that is not inflight, with no allocation, merge or selection for `IDLE_LIMIT` cycles, is offered `IDLE_LIMIT`+2 cycles after its last allocation or merge edge. A merge pulse restarts the count.
- R8: An entry allocated with the wait flag is not offered until the entry named by its wait index gets a hit response. If that hit arrives in the allocation cycle itself, no wait is recorded.
- R9: A hit response (`resp_miss_i`=0) sets bit `resp_idx_i` of `freed_o` in the same cycle and clears that entry's valid and inflight flags on the edge. A miss response leaves `freed_o` zero.
- R10: An entry whose `merge_busy_i` bit is high in a cycle is not selected in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_i | input | 1 | Allocate entry `alloc_idx_i` this cycle |
| alloc_idx_i | input | IDX_W | Entry being allocated |
| alloc_wait_i | input | 1 | New entry must wait on an inflight same-block entry |
| alloc_wait_idx_i | input | IDX_W | Entry the new one waits on |
| merge_busy_i | input | N_ENTRIES | Entries receiving a merge this cycle |
| flush_req_i | input | 1 | Drain everything |
| mismatch_i | input | 1 | Tag mismatch seen on entry `mismatch_idx_i` |
| mismatch_idx_i | input | IDX_W | Entry hit by the mismatch |
| req_valid_o | output | 1 | Cache write request valid |
| req_ready_i | input | 1 | Cache accepts the request |
| req_idx_o | output | IDX_W | Entry being written |
| resp_valid_i | input | 1 | Cache response valid |
| resp_idx_i | input | IDX_W | Entry the response belongs to |
| resp_miss_i | input | 1 | Response was a miss |
| freed_o | output | N_ENTRIES | Entries freed by a hit this cycle |
| valid_o | output | N_ENTRIES | Entry valid flags |
| inflight_o | output | N_ENTRIES | Entry inflight flags |
| flush_done_o | output | 1 | Flush requested and buffer empty |

## Verification
The hardest situation to reach is an allocation whose wait target receives its hit response in the very same cycle. A bench that only stores traffic would almost never line up those two events. A directed sequence forces one entry out with a mismatch pulse, lets it transfer, and then drives the hit and the dependent allocation on the same edge. It then checks that the new entry drains two cycles later. The replay and idle windows are checked at their exact cycle. A long seeded random phase with random ready, random miss responses, merges and chained waits compares the valid flags against a bench model every cycle.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int CLS_FORCE  = 0;
  localparam int CLS_REPLAY = 1;
  localparam int CLS_IDLE   = 2;
  localparam int CLS_BULK   = 3;
  localparam int NUM_CLS    = 4;

  function automatic int cnt_w(input longint unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/sbd_prio_pick.sv
module sbd_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/sbd_entry_ctl.sv
module sbd_entry_ctl
  import sbd_pkg::*;
#(
  parameter int          IDX_W        = 3,
  parameter int unsigned IDLE_LIMIT   = 1 << 20,
  parameter int unsigned REPLAY_LIMIT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             alloc_wait_i,
  input  logic [IDX_W-1:0] alloc_wait_idx_i,
  input  logic             sel_i,
  input  logic             hit_i,
  input  logic             miss_i,
  input  logic             dep_vld_i,
  input  logic [IDX_W-1:0] dep_idx_i,
  input  logic             touch_i,
  input  logic             force_i,
  output logic             valid_o,
  output logic             inflight_o,
  output logic             wait_o,
  output logic             replay_rdy_o,
  output logic             idle_rdy_o,
  output logic             forced_o
);
  localparam int IW = cnt_w(IDLE_LIMIT);
  localparam int RW = cnt_w(REPLAY_LIMIT);
  localparam logic [IW-1:0] IDLE_END = IW'(IDLE_LIMIT);
  localparam logic [RW-1:0] RPL_END  = RW'(REPLAY_LIMIT);

  logic             valid_q, infl_q, tmo_q, wait_q, forced_q;
  logic [IDX_W-1:0] widx_q;
  logic [IW-1:0]    idle_q;
  logic [RW-1:0]    rpl_q;

  logic dep_done, alloc_dep_done;
  assign dep_done       = dep_vld_i & wait_q & (widx_q == dep_idx_i);
  assign alloc_dep_done = dep_vld_i & (alloc_wait_idx_i == dep_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      infl_q   <= 1'b0;
      tmo_q    <= 1'b0;
      wait_q   <= 1'b0;
      forced_q <= 1'b0;
      widx_q   <= '0;
    end else if (alloc_i) begin
      valid_q  <= 1'b1;
      infl_q   <= 1'b0;
      tmo_q    <= 1'b0;
      forced_q <= 1'b0;
      // target already done this cycle: nothing to wait for
      wait_q   <= alloc_wait_i & ~alloc_dep_done;
      widx_q   <= alloc_wait_idx_i;
    end else if (hit_i) begin
      valid_q  <= 1'b0;
      infl_q   <= 1'b0;
      tmo_q    <= 1'b0;
      wait_q   <= 1'b0;
      forced_q <= 1'b0;
    end else begin
      if (force_i && valid_q && !infl_q) forced_q <= 1'b1;
      if (sel_i) begin
        infl_q   <= 1'b1;
        tmo_q    <= 1'b0;
        forced_q <= 1'b0;
      end else if (miss_i) begin
        tmo_q <= 1'b1;
      end
      if (dep_done) wait_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
    end else if (alloc_i || touch_i || sel_i) begin
      idle_q <= '0;
    end else if (valid_q && !infl_q && idle_q != IDLE_END) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rpl_q <= '0;
    end else if (miss_i) begin
      rpl_q <= '0;
    end else if (tmo_q && rpl_q != RPL_END) begin
      rpl_q <= rpl_q + 1'b1;
    end
  end

  assign valid_o      = valid_q;
  assign inflight_o   = infl_q;
  assign wait_o       = wait_q;
  assign forced_o     = forced_q;
  assign replay_rdy_o = tmo_q & (rpl_q == RPL_END);
  assign idle_rdy_o   = valid_q & ~infl_q & (idle_q == IDLE_END);
endmodule

// File: rtl/sbd_select.sv
module sbd_select
  import sbd_pkg::*;
#(
  parameter int N      = 8,
  parameter int IDX_W  = 3,
  parameter int THRESH = 6
) (
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     inflight_i,
  input  logic [N-1:0]     wait_i,
  input  logic [N-1:0]     replay_rdy_i,
  input  logic [N-1:0]     idle_rdy_i,
  input  logic [N-1:0]     forced_i,
  input  logic [N-1:0]     busy_i,
  input  logic             flush_i,
  input  logic             en_i,
  output logic             sel_vld_o,
  output logic [IDX_W-1:0] sel_idx_o,
  output logic [N-1:0]     sel_oh_o
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] occ;
  always_comb begin
    occ = '0;
    for (int i = 0; i < N; i++) occ = occ + CW'(valid_i[i]);
  end

  logic         bulk_on;
  logic [N-1:0] base, idle_n;
  assign bulk_on = flush_i | (occ >= CW'(THRESH));
  assign base    = valid_i & ~wait_i & ~busy_i & (~inflight_i | replay_rdy_i);
  assign idle_n  = base & ~inflight_i;

  logic [NUM_CLS-1:0][N-1:0]     cls;
  logic [NUM_CLS-1:0]            cls_any;
  logic [NUM_CLS-1:0][IDX_W-1:0] cls_idx;

  assign cls[CLS_FORCE]  = idle_n & forced_i;
  assign cls[CLS_REPLAY] = base & replay_rdy_i;
  assign cls[CLS_IDLE]   = idle_n & idle_rdy_i;
  assign cls[CLS_BULK]   = bulk_on ? idle_n : '0;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    sbd_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
      .req_i (cls[c]),
      .any_o (cls_any[c]),
      .idx_o (cls_idx[c])
    );
  end

  logic             any;
  logic [IDX_W-1:0] idx;
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int c = NUM_CLS - 1; c >= 0; c--) begin
      if (cls_any[c]) begin
        any = 1'b1;
        idx = cls_idx[c];
      end
    end
  end

  assign sel_vld_o = en_i & any;
  assign sel_idx_o = idx;
  always_comb begin
    sel_oh_o = '0;
    if (sel_vld_o) sel_oh_o[idx] = 1'b1;
  end
endmodule

// File: rtl/sbuf_drain_sched.sv
module sbuf_drain_sched
  import sbd_pkg::*;
#(
  parameter int          N_ENTRIES    = 16,
  parameter int          DRAIN_THRESH = 12,
  parameter int unsigned IDLE_LIMIT   = 1 << 20,
  parameter int unsigned REPLAY_LIMIT = 16,
  localparam int         IDX_W        = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 alloc_i,
  input  logic [IDX_W-1:0]     alloc_idx_i,
  input  logic                 alloc_wait_i,
  input  logic [IDX_W-1:0]     alloc_wait_idx_i,
  input  logic [N_ENTRIES-1:0] merge_busy_i,
  input  logic                 flush_req_i,
  input  logic                 mismatch_i,
  input  logic [IDX_W-1:0]     mismatch_idx_i,
  output logic                 req_valid_o,
  input  logic                 req_ready_i,
  output logic [IDX_W-1:0]     req_idx_o,
  input  logic                 resp_valid_i,
  input  logic [IDX_W-1:0]     resp_idx_i,
  input  logic                 resp_miss_i,
  output logic [N_ENTRIES-1:0] freed_o,
  output logic [N_ENTRIES-1:0] valid_o,
  output logic [N_ENTRIES-1:0] inflight_o,
  output logic                 flush_done_o
);
  logic [N_ENTRIES-1:0] wait_vec, rpl_rdy, idle_rdy, forced, sel_oh;
  logic                 hit_vld, miss_vld, can_sel, sel_vld;
  logic [IDX_W-1:0]     sel_idx;
  logic                 s1_vld_q;
  logic [IDX_W-1:0]     s1_idx_q;

  assign hit_vld  = resp_valid_i & ~resp_miss_i;
  assign miss_vld = resp_valid_i & resp_miss_i;
  assign can_sel  = ~s1_vld_q | req_ready_i;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic is_resp;
    assign is_resp    = resp_idx_i == IDX_W'(i);
    assign freed_o[i] = hit_vld & is_resp;

    sbd_entry_ctl #(
      .IDX_W        (IDX_W),
      .IDLE_LIMIT   (IDLE_LIMIT),
      .REPLAY_LIMIT (REPLAY_LIMIT)
    ) u_ent (
      .clk_i            (clk_i),
      .rst_ni           (rst_ni),
      .alloc_i          (alloc_i & (alloc_idx_i == IDX_W'(i))),
      .alloc_wait_i     (alloc_wait_i),
      .alloc_wait_idx_i (alloc_wait_idx_i),
      .sel_i            (sel_oh[i]),
      .hit_i            (hit_vld & is_resp),
      .miss_i           (miss_vld & is_resp),
      .dep_vld_i        (hit_vld),
      .dep_idx_i        (resp_idx_i),
      .touch_i          (merge_busy_i[i]),
      .force_i          (mismatch_i & (mismatch_idx_i == IDX_W'(i))),
      .valid_o          (valid_o[i]),
      .inflight_o       (inflight_o[i]),
      .wait_o           (wait_vec[i]),
      .replay_rdy_o     (rpl_rdy[i]),
      .idle_rdy_o       (idle_rdy[i]),
      .forced_o         (forced[i])
    );
  end

  sbd_select #(
    .N      (N_ENTRIES),
    .IDX_W  (IDX_W),
    .THRESH (DRAIN_THRESH)
  ) u_sel (
    .valid_i      (valid_o),
    .inflight_i   (inflight_o),
    .wait_i       (wait_vec),
    .replay_rdy_i (rpl_rdy),
    .idle_rdy_i   (idle_rdy),
    .forced_i     (forced),
    .busy_i       (merge_busy_i),
    .flush_i      (flush_req_i),
    .en_i         (can_sel),
    .sel_vld_o    (sel_vld),
    .sel_idx_o    (sel_idx),
    .sel_oh_o     (sel_oh)
  );

  // issue stage: latched pick, offered next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s1_idx_q <= '0;
    end else if (sel_vld) begin
      s1_vld_q <= 1'b1;
      s1_idx_q <= sel_idx;
    end else if (req_ready_i) begin
      s1_vld_q <= 1'b0;
    end
  end

  assign req_valid_o  = s1_vld_q;
  assign req_idx_o    = s1_idx_q;
  assign flush_done_o = flush_req_i & ~(|valid_o) & ~s1_vld_q;
endmodule

// File: rtl/sbuf_drain_sched_chk.sv
module sbuf_drain_sched_chk #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_req_i,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic [IDX_W-1:0] req_idx_o,
  input logic             resp_valid_i,
  input logic             resp_miss_i,
  input logic [IDX_W-1:0] resp_idx_i,
  input logic [N-1:0]     freed_o,
  input logic [N-1:0]     valid_o,
  input logic [N-1:0]     inflight_o,
  input logic             flush_done_o,
  input logic [N-1:0]     wait_vec
);
  a_r1_inflight_in_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inflight_o & ~valid_o) == '0);

  a_r5_offer_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_idx_o));

  a_r5_offer_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> valid_o[req_idx_o] && inflight_o[req_idx_o]);

  a_r8_waiter_not_sent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !wait_vec[req_idx_o]);

  a_r9_freed_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(freed_o));

  a_r9_freed_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_i && !resp_miss_i |-> freed_o[resp_idx_i]);

  a_r9_no_free_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_i && resp_miss_i |-> freed_o == '0);

  a_r9_hit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_i && !resp_miss_i |=> !inflight_o[$past(resp_idx_i)]);

  a_r6_miss_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_i && resp_miss_i |=> valid_o[$past(resp_idx_i)] && inflight_o[$past(resp_idx_i)]);

  a_r3_done_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |-> flush_req_i && valid_o == '0 && !req_valid_o);
endmodule

bind sbuf_drain_sched sbuf_drain_sched_chk #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_req_i  (flush_req_i),
  .req_valid_o  (req_valid_o),
  .req_ready_i  (req_ready_i),
  .req_idx_o    (req_idx_o),
  .resp_valid_i (resp_valid_i),
  .resp_miss_i  (resp_miss_i),
  .resp_idx_i   (resp_idx_i),
  .freed_o      (freed_o),
  .valid_o      (valid_o),
  .inflight_o   (inflight_o),
  .flush_done_o (flush_done_o),
  .wait_vec     (wait_vec)
);

// File: tb/sbuf_drain_sched_tb.sv
module sbuf_drain_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int IW = 3;
  localparam int TH = 6;
  localparam int IL = 200;
  localparam int RL = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic alloc_i = 0, alloc_wait_i = 0, flush_req_i = 0, mismatch_i = 0;
  logic [IW-1:0] alloc_idx_i = '0, alloc_wait_idx_i = '0, mismatch_idx_i = '0;
  logic [NE-1:0] merge_busy_i = '0;
  logic req_ready_i = 0, resp_valid_i = 0, resp_miss_i = 0;
  logic [IW-1:0] resp_idx_i = '0;
  logic req_valid_o, flush_done_o;
  logic [IW-1:0] req_idx_o;
  logic [NE-1:0] freed_o, valid_o, inflight_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sbuf_drain_sched #(
    .N_ENTRIES(NE), .DRAIN_THRESH(TH), .IDLE_LIMIT(IL), .REPLAY_LIMIT(RL)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .alloc_i(alloc_i), .alloc_idx_i(alloc_idx_i),
    .alloc_wait_i(alloc_wait_i), .alloc_wait_idx_i(alloc_wait_idx_i),
    .merge_busy_i(merge_busy_i), .flush_req_i(flush_req_i), .mismatch_i(mismatch_i),
    .mismatch_idx_i(mismatch_idx_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_idx_o(req_idx_o), .resp_valid_i(resp_valid_i), .resp_idx_i(resp_idx_i),
    .resp_miss_i(resp_miss_i), .freed_o(freed_o), .valid_o(valid_o),
    .inflight_o(inflight_o), .flush_done_o(flush_done_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [NE-1:0] m_valid = '0, m_wait = '0;
  logic [IW-1:0] m_widx [NE];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [NE-1:0] oh(input int i);
    return NE'(1) << i;
  endfunction

  task automatic alloc(input int idx, input bit w, input int widx);
    alloc_i = 1; alloc_idx_i = IW'(idx); alloc_wait_i = w; alloc_wait_idx_i = IW'(widx);
    step();
    alloc_i = 0; alloc_wait_i = 0;
  endtask

  task automatic mism(input int idx);
    mismatch_i = 1; mismatch_idx_i = IW'(idx);
    step();
    mismatch_i = 0;
  endtask

  task automatic wait_req();
    for (int n = 0; n < 400 && !req_valid_o; n++) step();
  endtask

  task automatic transfer();
    req_ready_i = 1;
    step();
    req_ready_i = 0;
  endtask

  task automatic respond(input int idx, input bit miss, input string tag);
    resp_valid_i = 1; resp_idx_i = IW'(idx); resp_miss_i = miss;
    #1;
    chk(freed_o == (miss ? '0 : oh(idx)), tag, freed_o, miss ? 0 : oh(idx));
    step();
    resp_valid_i = 0; resp_miss_i = 0;
  endtask

  task automatic send_and_hit(input int idx, input string tag);
    wait_req();
    chk(req_valid_o && req_idx_o == IW'(idx), tag, req_idx_o, idx);
    transfer();
    respond(idx, 1'b0, "R9 freed on hit");
  endtask

  task automatic quiet(input int cyc, input string tag);
    bit any = 0;
    for (int k = 0; k < cyc; k++) begin
      if (req_valid_o) any = 1;
      step();
    end
    chk(!any, tag, any, 0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) step();
    chk(!req_valid_o && valid_o == '0 && inflight_o == '0 && freed_o == '0 && !flush_done_o,
        "R1 reset state", {req_valid_o, valid_o}, 0);
    rst_ni = 1;
    step();

    // threshold drain
    for (int i = 0; i < TH - 1; i++) alloc(i, 0, 0);
    quiet(20, "R2 below threshold");
    alloc(TH - 1, 0, 0);
    chk(!req_valid_o, "R5 not yet offered", req_valid_o, 0);
    step();
    chk(req_valid_o && req_idx_o == 0, "R5 offered one cycle after pick", req_idx_o, 0);
    chk(inflight_o == oh(0), "R5 inflight from pick", inflight_o, oh(0));
    repeat (3) step();
    chk(req_valid_o && req_idx_o == 0, "R5 offer held without ready", req_idx_o, 0);
    send_and_hit(0, "R2 threshold drain");
    send_and_hit(1, "R2 threshold drain second");
    chk(valid_o == 8'b0011_1100, "R9 flags cleared", valid_o, 8'b0011_1100);
    quiet(20, "R2 drain stops below threshold");

    // flush, lowest index first
    flush_req_i = 1;
    for (int i = 2; i < TH; i++) begin
      chk(!flush_done_o, "R3 done low while valid", flush_done_o, 0);
      send_and_hit(i, "R3 flush order");
    end
    chk(flush_done_o, "R3 flush done", flush_done_o, 1);
    flush_req_i = 0;
    #1;
    chk(!flush_done_o, "R3 done needs flush", flush_done_o, 0);

    // mismatch and same-block wait
    alloc(0, 0, 0);
    mism(5);
    quiet(10, "R4 mismatch on invalid entry");
    mism(0);
    step();
    chk(req_valid_o && req_idx_o == 0, "R4 mismatch drains entry", req_idx_o, 0);
    transfer();
    alloc(1, 1, 0);
    mism(1);
    quiet(10, "R8 waiter held");
    respond(0, 1'b0, "R9 freed on hit");
    step();
    chk(req_valid_o && req_idx_o == 1, "R8 waiter released after hit", req_idx_o, 1);
    send_and_hit(1, "R8 waiter drains");

    // dependency freed in the allocation cycle
    alloc(0, 0, 0);
    mism(0);
    wait_req();
    transfer();
    resp_valid_i = 1; resp_idx_i = 0; resp_miss_i = 0;
    alloc_i = 1; alloc_idx_i = 1; alloc_wait_i = 1; alloc_wait_idx_i = 0;
    flush_req_i = 1;
    step();
    resp_valid_i = 0; alloc_i = 0; alloc_wait_i = 0;
    step();
    chk(req_valid_o && req_idx_o == 1, "R8 no wait on same-cycle free", req_idx_o, 1);
    send_and_hit(1, "R8 same-cycle free drains");
    flush_req_i = 0;

    // miss replay window
    alloc(3, 0, 0);
    flush_req_i = 1;
    wait_req();
    transfer();
    respond(3, 1'b1, "R9 no free on miss");
    chk(valid_o[3] && inflight_o[3], "R6 missed entry stays inflight", {valid_o[3], inflight_o[3]}, 3);
    begin
      bit early = 0;
      for (int k = 1; k <= RL + 1; k++) begin
        if (req_valid_o) early = 1;
        step();
      end
      chk(!early, "R6 no early replay", early, 0);
    end
    chk(req_valid_o && req_idx_o == 3, "R6 replay at exact cycle", req_valid_o, 1);
    send_and_hit(3, "R6 replay drains");
    chk(flush_done_o, "R3 done after replay", flush_done_o, 1);

    // merge blocks selection
    alloc(4, 0, 0);
    merge_busy_i = oh(4);
    quiet(10, "R10 merging entry held");
    merge_busy_i = '0;
    step();
    chk(req_valid_o && req_idx_o == 4, "R10 released after merge", req_idx_o, 4);
    send_and_hit(4, "R10 drains");
    flush_req_i = 0;

    // idle timeout with restart
    alloc(6, 0, 0);
    repeat (100) step();
    merge_busy_i = oh(6);
    step();
    merge_busy_i = '0;
    begin
      bit early = 0;
      for (int k = 1; k <= IL; k++) begin
        if (req_valid_o) early = 1;
        step();
      end
      chk(!early, "R7 no early idle drain", early, 0);
    end
    chk(!req_valid_o, "R7 not at limit+1", req_valid_o, 0);
    step();
    chk(req_valid_o && req_idx_o == 6, "R7 idle drain at limit+2", req_valid_o, 1);
    send_and_hit(6, "R7 idle drains");

    // seeded random traffic
    void'($urandom(32'h5eed_1234));
    begin
      bit pend = 0;
      int pidx = 0;
      for (int it = 0; it < 6000; it++) begin
        bit draining;
        int fidx;
        draining = it >= 4000;
        chk(valid_o == m_valid, "R9 valid flags vs model", valid_o, m_valid);
        if (draining && !pend && flush_done_o) break;
        resp_valid_i = 0; resp_miss_i = 0; alloc_i = 0; alloc_wait_i = 0;
        mismatch_i = 0; merge_busy_i = '0;
        fidx = -1;
        if (pend) begin
          resp_valid_i = 1; resp_idx_i = IW'(pidx);
          resp_miss_i = ($urandom % 4) == 0;
          pend = 0;
          if (!resp_miss_i) begin
            m_valid[pidx] = 0;
            for (int j = 0; j < NE; j++)
              if (m_wait[j] && m_widx[j] == IW'(pidx)) m_wait[j] = 0;
            fidx = pidx;
          end
        end
        req_ready_i = ($urandom % 3) != 0;
        if (req_valid_o && req_ready_i) begin
          chk(m_valid[req_idx_o] && !m_wait[req_idx_o], "R8 sent entry eligible",
              {m_valid[req_idx_o], m_wait[req_idx_o]}, 2);
          pend = 1; pidx = int'(req_idx_o);
        end
        if (!draining && ($urandom % 3) == 0) begin
          int i = int'($urandom % NE);
          if (!m_valid[i] && i != fidx) begin
            alloc_i = 1; alloc_idx_i = IW'(i);
            m_valid[i] = 1; m_wait[i] = 0;
            if ($urandom % 2) begin
              int t = int'($urandom % NE);
              if (t != i && m_valid[t]) begin
                alloc_wait_i = 1; alloc_wait_idx_i = IW'(t);
                m_wait[i] = 1; m_widx[i] = IW'(t);
              end
            end
          end
        end
        flush_req_i = draining || (($urandom % 8) == 0);
        if (($urandom % 10) == 0) begin mismatch_i = 1; mismatch_idx_i = IW'($urandom % NE); end
        if (($urandom % 12) == 0) merge_busy_i = oh(int'($urandom % NE));
        #1;
        if (resp_valid_i)
          chk(freed_o == (fidx >= 0 ? oh(fidx) : '0), "R9 freed vs response", freed_o,
              fidx >= 0 ? oh(fidx) : 0);
        step();
      end
    end
    resp_valid_i = 0; req_ready_i = 0;
    #1;
    chk(flush_done_o && m_valid == '0, "R3 random traffic fully drained", flush_done_o, 1);
    flush_req_i = 0;
    step();
    finish_run();
  end
endmodule